// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers characters from an asynchronous serial line that idles high. It runs from the system clock and uses a one-cycle enable, `tick`, that occurs sixteen times per bit period. The line is first passed through a flop synchronizer. A falling level on the idle line starts a frame. The receiver checks the line again half a bit later, then samples each following bit at its centre, one bit period apart.

The character format is selected at run time. `char_len` sets the number of data bits. `parity_mode` selects no parity, even parity or odd parity. For each frame the block outputs the character right-aligned in `rx_data`, together with a one-cycle `rx_valid` pulse and two error flags.

The receiver has no input for the number of stop bits. It looks only at the first stop bit and then returns to idle. The start bit of the next frame can therefore follow the first stop bit immediately, whether the sender emits one stop bit or two.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `frame_err`, `parity_err` and `rx_data` are zero. A line held high produces no output.
- R2: A low level is taken as a start bit only if the line is still low 8 ticks after the low was first seen. A shorter low pulse produces no output, and the receiver stays ready for the next frame.
- R3: Data bits arrive least significant bit first. `char_len` selects 5 to 9 bits: values below 5 act as 5 and values above 9 act as 9. Bits of `rx_data` above the character size are zero.
- R4: With `parity_mode` = 2'b01 (even parity), the bit after the last data bit is a parity bit. `parity_err` is set when that bit differs from the XOR of the data bits.
- R5: With `parity_mode` = 2'b10 (odd parity), `parity_err` is set when the parity bit differs from the inverted XOR of the data bits.
- R6: With `parity_mode` = 2'b00 or 2'b11, no parity bit is expected: the bit after the last data bit is the stop bit, and `parity_err` stays zero.
- R7: `frame_err` is set exactly when the first stop bit is sampled low. The character is still delivered.
- R8: Only the first stop bit is examined. A frame is accepted in the same way whether the sender follows it with a second high stop bit or goes straight to the next start bit.
- R9: A start bit that directly follows the first stop bit is received, so back-to-back frames are all delivered in order.
- R10: `rx_valid` is high for exactly one clock per frame. `frame_err` and `parity_err` can be high only in that clock.
- R11: The frame outputs appear in the clock after the tick at which the first stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rx | input | 1 | Asynchronous serial line, idle high |
| char_len | input | 4 | Data bits per character (5 to 9) |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| rx_data | output | 9 | Received character, right-aligned, zero-extended |
| rx_valid | output | 1 | One-clock pulse when a frame completes |
| frame_err | output | 1 | First stop bit was low (with rx_valid) |
| parity_err | output | 1 | Parity mismatch (with rx_valid) |

## Verification
The bound checker watches the output protocol on every cycle:
- `rx_valid` lasts a single clock, and the error flags never appear without it (R10).
- Each completion follows a tick (R11).
- No parity error is raised while parity is disabled (R6).
- Data bits above the configured size are zero (R3).

Other behaviours need a real line waveform, so only the bench's scenarios can show them:
- the bit order and the character content;
- the even and odd parity results;
- rejection of a short false start;
- a frame error on a low stop bit;
- reception of back-to-back frames, with one or two stop bits.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= 1'b1;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sfr_ovs_counter.sv
module sfr_ovs_counter #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic half_pt,
  output logic full_pt
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign half_pt = tick && (cnt == HALF);
  assign full_pt = tick && (cnt == LAST);
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int MAX_BITS = 9,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                shift,
  input  logic                bit_in,
  input  logic [LW-1:0]       len,
  output logic [MAX_BITS-1:0] word,
  output logic                par_xor
);
  logic [MAX_BITS-1:0] sh;
  logic [LW-1:0]       shamt;

  always_ff @(posedge clk) begin
    if (rst || clr) sh <= '0;
    else if (shift) sh <= {bit_in, sh[MAX_BITS-1:1]};
  end

  // bits enter at the top; the first (LSB) ends lowest after len shifts
  assign shamt   = LW'(MAX_BITS) - len;
  assign word    = sh >> shamt;
  assign par_xor = ^sh;
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int MAX_BITS    = 9,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rx,
  input  logic [LW-1:0]       char_len,
  input  logic [1:0]          parity_mode,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                frame_err,
  output logic                parity_err
);
  rx_state_e           state;
  logic                rx_s;
  logic                half_pt, full_pt, cnt_clr;
  logic                sh_clr, sh_go, par_xor, par_bit;
  logic [LW-1:0]       len_eff, bit_idx;
  logic [MAX_BITS-1:0] word;
  logic                par_en, par_odd;

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx), .q(rx_s)
  );

  sfr_ovs_counter #(.OVS(OVS)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr),
    .half_pt(half_pt), .full_pt(full_pt)
  );

  sfr_shifter #(.MAX_BITS(MAX_BITS), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .shift(sh_go), .bit_in(rx_s),
    .len(len_eff), .word(word), .par_xor(par_xor)
  );

  always_comb begin
    if (char_len < LW'(MIN_BITS))      len_eff = LW'(MIN_BITS);
    else if (char_len > LW'(MAX_BITS)) len_eff = LW'(MAX_BITS);
    else                               len_eff = char_len;
  end

  assign par_en  = parity_on(parity_mode);
  assign par_odd = (parity_mode == PAR_ODD);
  assign cnt_clr = (state == S_IDLE) || ((state == S_START) && half_pt);
  assign sh_clr  = (state == S_IDLE);
  assign sh_go   = (state == S_DATA) && full_pt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      bit_idx    <= '0;
      par_bit    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      case (state)
        S_IDLE: begin
          bit_idx <= '0;
          if (tick && !rx_s) state <= S_START;
        end
        S_START: begin
          if (half_pt) state <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: begin
          if (full_pt) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == len_eff - 1'b1)
              state <= par_en ? S_PARITY : S_STOP;
          end
        end
        S_PARITY: begin
          if (full_pt) begin
            par_bit <= rx_s;
            state   <= S_STOP;
          end
        end
        S_STOP: begin
          if (full_pt) begin
            rx_valid   <= 1'b1;
            rx_data    <= word;
            frame_err  <= !rx_s;
            parity_err <= par_en && ((par_xor ^ par_odd) != par_bit);
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int MAX_BITS = 9,
  parameter int MIN_BITS = 5,
  parameter int LW = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic [LW-1:0]       char_len,
  input logic [1:0]          parity_mode,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_valid,
  input logic                frame_err,
  input logic                parity_err
);
  logic [LW-1:0] len_c;
  always_comb begin
    if (char_len < LW'(MIN_BITS))      len_c = LW'(MIN_BITS);
    else if (char_len > LW'(MAX_BITS)) len_c = LW'(MAX_BITS);
    else                               len_c = char_len;
  end

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_err || parity_err) |-> rx_valid);

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_after_tick_R11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(tick));

  assert_no_parity_err_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    parity_err |-> ($past(parity_mode) == 2'b01 || $past(parity_mode) == 2'b10));

  assert_upper_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> $past(len_c)) == '0));
endmodule

bind serial_frame_rx sfr_checker #(
  .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LW(LW)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .char_len(char_len),
  .parity_mode(parity_mode), .rx_data(rx_data), .rx_valid(rx_valid),
  .frame_err(frame_err), .parity_err(parity_err)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [3:0] char_len = 4'd8;
  logic [1:0] parity_mode = 2'b00;
  logic [8:0] rx_data;
  logic       rx_valid, frame_err, parity_err;

  int vectors = 0;
  int fails = 0;
  int cap_cnt = 0;
  logic [8:0] cap_data [64];
  logic       cap_fe [64];
  logic       cap_pe [64];
  bit         done = 0;

  serial_frame_rx dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx), .char_len(char_len),
    .parity_mode(parity_mode), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // tick generator and output monitor, both at the falling edge
  initial begin
    int  divc = 0;
    bit  prev_v = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rx_valid) begin
          chk(tick, "R11 valid follows tick", tick, 1);
          chk(!prev_v, "R10 valid one clock", 2, 1);
          if (cap_cnt < 64) begin
            cap_data[cap_cnt] = rx_data;
            cap_fe[cap_cnt]   = frame_err;
            cap_pe[cap_cnt]   = parity_err;
          end
          cap_cnt++;
        end else if (frame_err || parity_err) begin
          chk(0, "R10 flag without valid", 1, 0);
        end
        prev_v = rx_valid;
      end
      divc = (divc == 3) ? 0 : divc + 1;
      tick = (divc == 3);
    end
  end

  task automatic hold(input logic v, input int ticks);
    rx = v;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int n, input logic [1:0] pm,
                            input bit flip_par, input bit bad_stop, input int nstop);
    logic p;
    p = 1'b0;
    hold(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      hold(d[i], 16);
      p ^= d[i];
    end
    if (pm == 2'b01 || pm == 2'b10) hold(p ^ (pm == 2'b10) ^ flip_par, 16);
    if (bad_stop) begin
      hold(1'b0, 10);
      hold(1'b1, 6);
    end else begin
      hold(1'b1, 16);
    end
    if (nstop == 2) hold(1'b1, 16);
  endtask

  task automatic expect_frame(input int idx, input logic [8:0] d, input int n,
                              input bit fe, input bit pe, input string req);
    logic [8:0] m;
    m = d & ((9'h1 << n) - 9'h1);
    chk(cap_data[idx] == m, {req, " data"}, int'(cap_data[idx]), int'(m));
    chk(cap_fe[idx] == fe, {req, " frame_err"}, int'(cap_fe[idx]), int'(fe));
    chk(cap_pe[idx] == pe, {req, " parity_err"}, int'(cap_pe[idx]), int'(pe));
  endtask

  task automatic t_reset;
    chk(rx_valid == 0 && frame_err == 0 && parity_err == 0, "R1 reset flags", 
        int'({rx_valid, frame_err, parity_err}), 0);
    chk(rx_data == 0, "R1 reset data", int'(rx_data), 0);
    hold(1'b1, 64);
    chk(cap_cnt == 0, "R1 idle line silent", cap_cnt, 0);
  endtask

  task automatic t_lengths;
    parity_mode = 2'b00;
    for (int n = 5; n <= 9; n++) begin
      int base = cap_cnt;
      char_len = 4'(n);
      send_frame(9'h1A5, n, 2'b00, 0, 0, 1);
      hold(1'b1, 16);
      chk(cap_cnt == base + 1, "R3 frame count", cap_cnt, base + 1);
      expect_frame(base, 9'h1A5, n, 0, 0, "R3/R6 length");
    end
  endtask

  task automatic t_parity(input logic [1:0] pm, input string req);
    int base = cap_cnt;
    parity_mode = pm;
    char_len = 4'd8;
    send_frame(9'h0B3, 8, pm, 0, 0, 1);
    hold(1'b1, 16);
    send_frame(9'h0B3, 8, pm, 1, 0, 1);
    hold(1'b1, 16);
    send_frame(9'h07E, 8, pm, 0, 0, 1);
    hold(1'b1, 16);
    chk(cap_cnt == base + 3, {req, " count"}, cap_cnt, base + 3);
    expect_frame(base,     9'h0B3, 8, 0, 0, {req, " good"});
    expect_frame(base + 1, 9'h0B3, 8, 0, 1, {req, " flipped"});
    expect_frame(base + 2, 9'h07E, 8, 0, 0, {req, " good even-weight"});
  endtask

  task automatic t_frame_err;
    int base = cap_cnt;
    parity_mode = 2'b00;
    char_len = 4'd7;
    send_frame(9'h055, 7, 2'b00, 0, 1, 1);
    hold(1'b1, 48);
    send_frame(9'h02A, 7, 2'b00, 0, 0, 1);
    hold(1'b1, 16);
    chk(cap_cnt == base + 2, "R7 count", cap_cnt, base + 2);
    expect_frame(base,     9'h055, 7, 1, 0, "R7 low stop");
    expect_frame(base + 1, 9'h02A, 7, 0, 0, "R7 next clean");
  endtask

  task automatic t_glitch;
    int base = cap_cnt;
    char_len = 4'd8;
    parity_mode = 2'b00;
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk(cap_cnt == base, "R2 short low ignored", cap_cnt, base);
    send_frame(9'h0C3, 8, 2'b00, 0, 0, 1);
    hold(1'b1, 16);
    chk(cap_cnt == base + 1, "R2 ready after glitch", cap_cnt, base + 1);
    expect_frame(base, 9'h0C3, 8, 0, 0, "R2 frame after glitch");
  endtask

  task automatic t_back_to_back;
    int base = cap_cnt;
    char_len = 4'd9;
    parity_mode = 2'b10;
    send_frame(9'h1F0, 9, 2'b10, 0, 0, 1);
    send_frame(9'h00F, 9, 2'b10, 0, 0, 1);
    send_frame(9'h133, 9, 2'b10, 0, 0, 1);
    hold(1'b1, 16);
    chk(cap_cnt == base + 3, "R9 back-to-back count", cap_cnt, base + 3);
    expect_frame(base,     9'h1F0, 9, 0, 0, "R9 first");
    expect_frame(base + 1, 9'h00F, 9, 0, 0, "R9 second");
    expect_frame(base + 2, 9'h133, 9, 0, 0, "R9 third");
  endtask

  task automatic t_two_stop;
    int base = cap_cnt;
    char_len = 4'd6;
    parity_mode = 2'b01;
    send_frame(9'h02D, 6, 2'b01, 0, 0, 2);
    send_frame(9'h012, 6, 2'b01, 0, 0, 1);
    send_frame(9'h03F, 6, 2'b01, 0, 0, 2);
    hold(1'b1, 16);
    chk(cap_cnt == base + 3, "R8 stop count mix", cap_cnt, base + 3);
    expect_frame(base,     9'h02D, 6, 0, 0, "R8 two stops");
    expect_frame(base + 1, 9'h012, 6, 0, 0, "R8 one stop");
    expect_frame(base + 2, 9'h03F, 6, 0, 0, "R8 two stops again");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rx = 1'b1;
    rst = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_parity(2'b01, "R4 even");
    t_parity(2'b10, "R5 odd");
    t_frame_err();
    t_glitch();
    t_back_to_back();
    t_two_stop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule